// File: doc/BRIEF.md
# T1 DS0 Idle and Zero-Suppression Inserter

This block sits in the transmit path of a T1 framer. It handles the 8-bit channel bytes of each 24-channel frame. Each byte arrives with a channel index and a frame-start flag. Any channel flagged in an idle-select mask has its byte replaced by one programmable idle byte. When zero-code suppression is on, a byte that is still all zeros after that replacement is sent as a stuffed byte with a single one in it, so the AMI line keeps its pulse density. Channels flagged in a second mask are carried clear: they are never stuffed.

The configuration is presented on plain input buses. The block copies it into working registers only on a byte that starts a frame, so a frame is never processed with two different settings. The output is registered: each accepted byte appears one clock later, together with its channel index and frame-start flag.

Top module: `t1_ds0_scrub`

## Requirements
- R1: While reset is high and on the first edge after it, out_valid, out_sof, out_chan and out_data are all zero.
- R2: A byte accepted with in_valid high appears on out_data exactly one clock later with out_valid high. out_chan and out_sof repeat that byte's channel index and frame-start flag. out_valid is low one clock after a cycle with in_valid low.
- R3: For a channel index below 24 whose idle-select bit is set, the output is the configured idle byte, unless R7 applies.
- R4: With zero-code suppression off, a byte in a channel that is not idle-selected passes unchanged, including 8'h00. The clear-channel mask has no effect.
- R5: With zero-code suppression on, an 8'h00 byte in a channel that is neither clear nor idle-selected leaves as 8'h02 (bit index 1, counting from the LSB as 0). Non-zero bytes pass unchanged.
- R6: A channel whose clear-channel bit is set is never stuffed. An 8'h00 byte in it stays 8'h00 even with suppression on.
- R7: Idle substitution comes before suppression. An idle byte of 8'h00 in an idle-selected, non-clear channel leaves as 8'h02 when suppression is on, and as 8'h00 in a clear channel.
- R8: Mask bit n of the idle-select and clear-channel masks belongs to channel index n (0 to 23). Setting one bit affects only that channel.
- R9: The idle byte, both masks and the suppression enable are taken into use only on a byte accepted with in_valid and in_sof both high. That byte already uses the new values. Changes presented at any other time have no effect until the next such byte.
- R10: A byte whose channel index is 24 to 31 passes unchanged, whatever the configuration.
- R11: While out_valid is low, out_data and out_chan keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Byte is the first of a frame; loads the configuration |
| in_chan | input | 5 | Channel index, 0 to 23 |
| in_data | input | 8 | Channel byte |
| cfg_idle_byte | input | 8 | Idle byte to substitute |
| cfg_idle_mask | input | 24 | Idle-select mask, bit n for channel n |
| cfg_clear_mask | input | 24 | Clear-channel mask, bit n for channel n |
| cfg_zcs_en | input | 1 | Zero-code suppression enable |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Frame-start flag of the output byte |
| out_chan | output | 5 | Channel index of the output byte |
| out_data | output | 8 | Processed channel byte |

## Verification
The assertions assume that reset is held for at least one edge and that in_sof has meaning only together with in_valid. They also assume the configuration buses are free to change in any cycle, since only the working copy is checked for stability. The bench drives every input on the falling clock edge. It changes the configuration only between bytes, and it pairs every configuration change with a frame-start byte whenever the change is meant to take effect. It also sends indices 24 to 31 on purpose, to exercise the out-of-range path.

// File: rtl/t1ds0_pkg.sv
package t1ds0_pkg;
  localparam int unsigned T1_SLOTS  = 24;
  localparam int unsigned SLOT_BITS = 8;
  localparam int unsigned STUFF_POS = 1;

  // Action chosen for one channel byte
  typedef enum logic [1:0] {
    ACT_PASS  = 2'd0,
    ACT_IDLE  = 2'd1,
    ACT_STUFF = 2'd2
  } ds0_act_t;
endpackage

// File: rtl/t1ds0_cfg_shadow.sv
module t1ds0_cfg_shadow #(
  parameter int NUM_CH = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] nxt_idle_byte,
  input  logic [NUM_CH-1:0] nxt_idle_mask,
  input  logic [NUM_CH-1:0] nxt_clear_mask,
  input  logic              nxt_zcs_en,
  output logic [BYTE_W-1:0] eff_idle_byte,
  output logic [NUM_CH-1:0] eff_idle_mask,
  output logic [NUM_CH-1:0] eff_clear_mask,
  output logic              eff_zcs_en
);
  logic [BYTE_W-1:0] sh_idle_byte;
  logic [NUM_CH-1:0] sh_idle_mask;
  logic [NUM_CH-1:0] sh_clear_mask;
  logic              sh_zcs_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_idle_byte  <= '0;
      sh_idle_mask  <= '0;
      sh_clear_mask <= '0;
      sh_zcs_en     <= 1'b0;
    end else if (load) begin
      sh_idle_byte  <= nxt_idle_byte;
      sh_idle_mask  <= nxt_idle_mask;
      sh_clear_mask <= nxt_clear_mask;
      sh_zcs_en     <= nxt_zcs_en;
    end
  end

  // The frame-start byte itself already sees the new settings
  always_comb begin
    if (load) begin
      eff_idle_byte  = nxt_idle_byte;
      eff_idle_mask  = nxt_idle_mask;
      eff_clear_mask = nxt_clear_mask;
      eff_zcs_en     = nxt_zcs_en;
    end else begin
      eff_idle_byte  = sh_idle_byte;
      eff_idle_mask  = sh_idle_mask;
      eff_clear_mask = sh_clear_mask;
      eff_zcs_en     = sh_zcs_en;
    end
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(sh_idle_mask) && $stable(sh_clear_mask) &&
               $stable(sh_idle_byte) && $stable(sh_zcs_en))); // R9
endmodule

// File: rtl/t1ds0_chan_sel.sv
module t1ds0_chan_sel #(
  parameter int NUM_CH = 24,
  parameter int CH_W   = 5
) (
  input  logic [CH_W-1:0]   chan,
  input  logic [NUM_CH-1:0] idle_mask,
  input  logic [NUM_CH-1:0] clear_mask,
  output logic              in_range,
  output logic              idle_hit,
  output logic              clear_hit
);
  logic [NUM_CH-1:0] sel;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign sel[g] = (chan == CH_W'(g));
  end

  assign in_range  = |sel;
  assign idle_hit  = |(sel & idle_mask);
  assign clear_hit = |(sel & clear_mask);
endmodule

// File: rtl/t1ds0_byte_xform.sv
module t1ds0_byte_xform
  import t1ds0_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] data,
  input  logic [BYTE_W-1:0] idle_byte,
  input  logic              in_range,
  input  logic              idle_hit,
  input  logic              clear_hit,
  input  logic              zcs_en,
  output ds0_act_t          act
);
  logic [BYTE_W-1:0] after_idle;
  logic              use_idle;
  logic              may_stuff;

  assign use_idle   = in_range && idle_hit;
  assign after_idle = use_idle ? idle_byte : data;
  assign may_stuff  = in_range && zcs_en && !clear_hit;

  always_comb begin
    if (may_stuff && (after_idle == '0)) act = ACT_STUFF;
    else if (use_idle)                   act = ACT_IDLE;
    else                                 act = ACT_PASS;
  end
endmodule

// File: rtl/t1_ds0_scrub.sv
module t1_ds0_scrub
  import t1ds0_pkg::*;
#(
  parameter  int NUM_CH    = T1_SLOTS,
  parameter  int BYTE_W    = SLOT_BITS,
  parameter  int STUFF_BIT = STUFF_POS,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [BYTE_W-1:0] cfg_idle_byte,
  input  logic [NUM_CH-1:0] cfg_idle_mask,
  input  logic [NUM_CH-1:0] cfg_clear_mask,
  input  logic              cfg_zcs_en,
  output logic              out_valid,
  output logic              out_sof,
  output logic [CH_W-1:0]   out_chan,
  output logic [BYTE_W-1:0] out_data
);
  localparam logic [BYTE_W-1:0] STUFF_WORD = BYTE_W'(1) << STUFF_BIT;

  logic              cfg_load;
  logic [BYTE_W-1:0] eff_idle_byte;
  logic [NUM_CH-1:0] eff_idle_mask;
  logic [NUM_CH-1:0] eff_clear_mask;
  logic              eff_zcs_en;
  logic              in_range;
  logic              idle_hit;
  logic              clear_hit;
  ds0_act_t          act;
  logic [BYTE_W-1:0] nxt_data;

  assign cfg_load = in_valid && in_sof;

  t1ds0_cfg_shadow #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_cfg (
    .clk           (clk),
    .rst           (rst),
    .load          (cfg_load),
    .nxt_idle_byte (cfg_idle_byte),
    .nxt_idle_mask (cfg_idle_mask),
    .nxt_clear_mask(cfg_clear_mask),
    .nxt_zcs_en    (cfg_zcs_en),
    .eff_idle_byte (eff_idle_byte),
    .eff_idle_mask (eff_idle_mask),
    .eff_clear_mask(eff_clear_mask),
    .eff_zcs_en    (eff_zcs_en)
  );

  t1ds0_chan_sel #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sel (
    .chan      (in_chan),
    .idle_mask (eff_idle_mask),
    .clear_mask(eff_clear_mask),
    .in_range  (in_range),
    .idle_hit  (idle_hit),
    .clear_hit (clear_hit)
  );

  t1ds0_byte_xform #(.BYTE_W(BYTE_W)) u_xf (
    .data     (in_data),
    .idle_byte(eff_idle_byte),
    .in_range (in_range),
    .idle_hit (idle_hit),
    .clear_hit(clear_hit),
    .zcs_en   (eff_zcs_en),
    .act      (act)
  );

  always_comb begin
    case (act)
      ACT_IDLE:  nxt_data = eff_idle_byte;
      ACT_STUFF: nxt_data = STUFF_WORD;
      default:   nxt_data = in_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_sof   <= in_valid && in_sof;
      if (in_valid) begin
        out_chan <= in_chan;
        out_data <= nxt_data;
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid && out_chan == $past(in_chan))); // R2
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_GAP: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_data) && $stable(out_chan))); // R11
  AST_NO_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_range && eff_zcs_en && !clear_hit) |=> (out_data != '0)); // R5
  AST_CLEAR_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_range && clear_hit && !idle_hit) |=> (out_data == $past(in_data))); // R6
  AST_RANGE_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_range) |=> (out_data == $past(in_data))); // R10
  AST_IDLE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_range && idle_hit && eff_idle_byte != '0) |=> (out_data == $past(eff_idle_byte))); // R3
endmodule

// File: tb/t1_ds0_scrub_tb.sv
`timescale 1ns/1ps
module t1_ds0_scrub_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_sof;
  logic [4:0]  in_chan;
  logic [7:0]  in_data;
  logic [7:0]  cfg_idle_byte;
  logic [23:0] cfg_idle_mask, cfg_clear_mask;
  logic        cfg_zcs_en;
  logic        out_valid, out_sof;
  logic [4:0]  out_chan;
  logic [7:0]  out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  t1_ds0_scrub dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_chan(in_chan), .in_data(in_data),
    .cfg_idle_byte(cfg_idle_byte), .cfg_idle_mask(cfg_idle_mask),
    .cfg_clear_mask(cfg_clear_mask), .cfg_zcs_en(cfg_zcs_en),
    .out_valid(out_valid), .out_sof(out_sof), .out_chan(out_chan),
    .out_data(out_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge
  task automatic send(input logic sof, input logic [4:0] ch, input logic [7:0] d,
                      input logic [7:0] exp, input string req);
    in_valid = 1'b1; in_sof = sof; in_chan = ch; in_data = d;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    chk({req, " data"}, 32'(out_data), 32'(exp));
    chk("R2 valid", 32'(out_valid), 32'd1);
    chk("R2 chan", 32'(out_chan), 32'(ch));
    chk("R2 sof", 32'(out_sof), 32'(sof));
  endtask

  task automatic set_cfg(input logic [7:0] ib, input logic [23:0] im,
                         input logic [23:0] cm, input logic z);
    cfg_idle_byte = ib; cfg_idle_mask = im; cfg_clear_mask = cm; cfg_zcs_en = z;
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0; in_chan = '0; in_data = '0;
    set_cfg(8'h00, '0, '0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    chk("R1 data in reset", 32'(out_data), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after", 32'(out_valid), 32'd0);
    chk("R1 sof after", 32'(out_sof), 32'd0);
    chk("R1 chan after", 32'(out_chan), 32'd0);
  endtask

  task automatic t_pass_off;
    set_cfg(8'h7E, 24'h000000, 24'h000040, 1'b0);
    send(1'b1, 5'd0, 8'h00, 8'h00, "R4 zero passes");
    send(1'b0, 5'd6, 8'h00, 8'h00, "R4 clear mask ignored");
    send(1'b0, 5'd5, 8'hA5, 8'hA5, "R4 data passes");
    @(negedge clk);
    chk("R2 no valid in gap", 32'(out_valid), 32'd0);
    chk("R11 data held", 32'(out_data), 32'hA5);
    chk("R11 chan held", 32'(out_chan), 32'd5);
  endtask

  task automatic t_idle;
    set_cfg(8'h7E, 24'h800008, 24'h000000, 1'b0);
    send(1'b1, 5'd0, 8'h11, 8'h11, "R8 ch0 untouched");
    send(1'b0, 5'd3, 8'h11, 8'h7E, "R3 ch3 idle");
    send(1'b0, 5'd4, 8'h11, 8'h11, "R8 ch4 untouched");
    send(1'b0, 5'd23, 8'h33, 8'h7E, "R3 ch23 idle");
  endtask

  task automatic t_staging;
    set_cfg(8'h55, 24'h000011, 24'h000000, 1'b1);
    send(1'b0, 5'd4, 8'h11, 8'h11, "R9 no mid-frame mask");
    send(1'b0, 5'd3, 8'h22, 8'h7E, "R9 old idle kept");
    send(1'b0, 5'd9, 8'h00, 8'h00, "R9 no mid-frame zcs");
    send(1'b1, 5'd0, 8'h22, 8'h55, "R9 sof byte uses new");
    send(1'b0, 5'd4, 8'h11, 8'h55, "R9 new mask active");
    send(1'b0, 5'd3, 8'h22, 8'h22, "R9 old mask gone");
  endtask

  task automatic t_zcs;
    set_cfg(8'h7E, 24'h000000, 24'h000040, 1'b1);
    send(1'b1, 5'd0, 8'h00, 8'h02, "R5 zero stuffed");
    send(1'b0, 5'd1, 8'h40, 8'h40, "R5 nonzero kept");
    send(1'b0, 5'd6, 8'h00, 8'h00, "R6 clear not stuffed");
    send(1'b0, 5'd7, 8'h00, 8'h02, "R5 neighbour stuffed");
  endtask

  task automatic t_order;
    set_cfg(8'h00, 24'h000044, 24'h000040, 1'b1);
    send(1'b1, 5'd2, 8'hFF, 8'h02, "R7 idle zero stuffed");
    send(1'b0, 5'd6, 8'hFF, 8'h00, "R7 idle zero clear");
    set_cfg(8'h00, 24'h000044, 24'h000040, 1'b0);
    send(1'b1, 5'd2, 8'hFF, 8'h00, "R7 idle zero no zcs");
  endtask

  task automatic t_range;
    set_cfg(8'h7E, 24'hFFFFFF, 24'h000000, 1'b1);
    send(1'b1, 5'd0, 8'h00, 8'h7E, "R3 all idle");
    send(1'b0, 5'd25, 8'h00, 8'h00, "R10 idx 25 zero");
    send(1'b0, 5'd31, 8'h9C, 8'h9C, "R10 idx 31 data");
    send(1'b0, 5'd24, 8'h00, 8'h00, "R10 idx 24 zero");
  endtask

  initial begin
    t_reset();
    t_pass_off();
    t_idle();
    t_staging();
    t_zcs();
    t_order();
    t_range();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule